// File: doc/BRIEF.md
# Sweeping-Frequency Phase Generator

This block produces the phase word for a numerically controlled oscillator whose frequency can be swept linearly. It holds two registers. A phase accumulator gains the current step every clock. A step register sets the output frequency. In the sweeping modes, a programmable delta changes the step register by a fixed amount every clock. Only the low 24 bits of the step take part in this change. The step therefore moves in a straight line between a programmable lower bound and a programmable upper bound.

A controller programs the phase offset, the two bounds, the delta and a mode. It then pulses a load strobe. From that point the block runs by itself. It can sweep upward and wrap, sweep downward and wrap, or bounce upward then downward in a repeating cycle. A restart flag marks every cycle in which the step has just been reloaded. A sine/cosine table further down the chain can use that flag to align to the sweep period.

Top module: `chirp_nco`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `phase_o` is 0 and `restart_o` is 0. The step is 0 and the mode is fixed.
- R2: A clock edge with `load_i` high sets the following values. `phase_o` becomes `offset_i` and `restart_o` goes to 1 for one cycle. The step is loaded with `inc_max_i` when `mode_i` is down. For every other mode it is loaded with `inc_min_i`. This happens whatever the sweep is doing at the time.
- R3: On every edge without load, `phase_o` grows by the current step, modulo 2^32. The wrap sets no flag.
- R4: In fixed mode (`mode_i` = 0 at load), the step never changes until the next load.
- R5: In up mode (`mode_i` = 1), each edge adds `delta_i` to the low 24 bits of the step. Two conditions each count as overshoot: a carry out of bit 23, or a result above `inc_max_i`. On overshoot the step is reloaded with `inc_min_i` instead, and `restart_o` is 1 in the next cycle.
- R6: In down mode (`mode_i` = 2), each edge subtracts `delta_i` from the low 24 bits of the step. Two conditions each count as undershoot: a borrow out of bit 23, or a result below `inc_min_i`. On undershoot the step is reloaded with `inc_max_i` instead, with `restart_o` set.
- R7: In up/down mode (`mode_i` = 3), the step first rises as in R5. On the edge where a rise would overshoot, the step holds and the direction turns downward. It then falls each edge. On the edge where a fall would undershoot, the step is reloaded with `inc_min_i`, `restart_o` is set, and rising begins again.
- R8: Bits 31..24 of the step change only on reloads, never through the delta.
- R9: `mode_i` is sampled only on a load edge. Changing it at any other time has no effect on the sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Start strobe: applies offset, mode and starting step |
| mode_i | input | 2 | 0 fixed, 1 up, 2 down, 3 up/down |
| offset_i | input | 32 | Starting phase |
| inc_min_i | input | 32 | Lower step bound |
| inc_max_i | input | 32 | Upper step bound |
| delta_i | input | 24 | Step change per clock |
| phase_o | output | 32 | Phase word |
| restart_o | output | 1 | Step was just reloaded |

## Verification
The hardest cases to reach are the ones where the sweep ends because the low 24 bits carry or borrow, not because a bound is crossed. A carry or borrow needs a starting step whose low field already sits close to all-ones or close to zero. The bench sets bounds so that the upper byte is non-zero and the low field reaches its edge within a few steps. It then follows the step through the phase differences. A near-exhaustive sweep covers every sweep mode, every small delta and several upper bounds, so the turn-around hold cycle is hit at every offset from the bound.

// File: rtl/chirp_pkg.sv
package chirp_pkg;
    typedef enum logic [1:0] {
        MODE_FIXED  = 2'd0,
        MODE_UP     = 2'd1,
        MODE_DOWN   = 2'd2,
        MODE_UPDOWN = 2'd3
    } chirp_mode_e;
endpackage

// File: rtl/chirp_step.sv
// Proposes the next step value: low DELTA_W bits moved by delta, upper bits kept.
// Flags when the move leaves the low field or crosses the bound.
module chirp_step #(
    parameter int PHASE_W  = 32,
    parameter int DELTA_W  = 24,
    parameter bit SUBTRACT = 1'b0
) (
    input  logic [PHASE_W-1:0] inc_i,
    input  logic [DELTA_W-1:0] delta_i,
    input  logic [PHASE_W-1:0] limit_i,
    output logic [PHASE_W-1:0] cand_o,
    output logic               beyond_o
);
    logic [DELTA_W:0] low_ext;

    generate
        if (SUBTRACT) begin : g_sub
            assign low_ext  = {1'b0, inc_i[DELTA_W-1:0]} - {1'b0, delta_i};
        end else begin : g_add
            assign low_ext  = {1'b0, inc_i[DELTA_W-1:0]} + {1'b0, delta_i};
        end

        if (DELTA_W < PHASE_W) begin : g_split
            assign cand_o = {inc_i[PHASE_W-1:DELTA_W], low_ext[DELTA_W-1:0]};
        end else begin : g_full
            assign cand_o = low_ext[DELTA_W-1:0];
        end

        if (SUBTRACT) begin : g_lo_bound
            assign beyond_o = low_ext[DELTA_W] || (cand_o < limit_i);
        end else begin : g_hi_bound
            assign beyond_o = low_ext[DELTA_W] || (cand_o > limit_i);
        end
    endgenerate
endmodule

// File: rtl/chirp_phase_acc.sv
// Modulo 2^PHASE_W phase adder; carry out is discarded on purpose.
module chirp_phase_acc #(
    parameter int PHASE_W = 32
) (
    input  logic [PHASE_W-1:0] acc_i,
    input  logic [PHASE_W-1:0] inc_i,
    output logic [PHASE_W-1:0] sum_o
);
    assign sum_o = acc_i + inc_i;
endmodule

// File: rtl/chirp_nco.sv
module chirp_nco #(
    parameter int PHASE_W = 32,
    parameter int DELTA_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [1:0]         mode_i,
    input  logic [PHASE_W-1:0] offset_i,
    input  logic [PHASE_W-1:0] inc_min_i,
    input  logic [PHASE_W-1:0] inc_max_i,
    input  logic [DELTA_W-1:0] delta_i,
    output logic [PHASE_W-1:0] phase_o,
    output logic               restart_o
);
    import chirp_pkg::*;

    typedef struct packed {
        logic [PHASE_W-1:0] acc;
        logic [PHASE_W-1:0] inc;
        chirp_mode_e        mode;
        logic               dir_up;
        logic               restart;
    } state_t;

    state_t state_d, state_q;

    logic [PHASE_W-1:0] acc_next;
    logic [PHASE_W-1:0] up_cand, dn_cand;
    logic               up_beyond, dn_beyond;
    chirp_mode_e        mode_in;

    assign mode_in = chirp_mode_e'(mode_i);

    chirp_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
        .acc_i (state_q.acc),
        .inc_i (state_q.inc),
        .sum_o (acc_next)
    );

    chirp_step #(.PHASE_W(PHASE_W), .DELTA_W(DELTA_W), .SUBTRACT(1'b0)) u_rise (
        .inc_i    (state_q.inc),
        .delta_i  (delta_i),
        .limit_i  (inc_max_i),
        .cand_o   (up_cand),
        .beyond_o (up_beyond)
    );

    chirp_step #(.PHASE_W(PHASE_W), .DELTA_W(DELTA_W), .SUBTRACT(1'b1)) u_fall (
        .inc_i    (state_q.inc),
        .delta_i  (delta_i),
        .limit_i  (inc_min_i),
        .cand_o   (dn_cand),
        .beyond_o (dn_beyond)
    );

    always_comb begin
        state_d         = state_q;
        state_d.restart = 1'b0;
        state_d.acc     = acc_next;
        if (load_i) begin
            state_d.acc     = offset_i;
            state_d.mode    = mode_in;
            state_d.inc     = (mode_in == MODE_DOWN) ? inc_max_i : inc_min_i;
            state_d.dir_up  = 1'b1;
            state_d.restart = 1'b1;
        end else begin
            unique case (state_q.mode)
                MODE_UP: begin
                    if (up_beyond) begin
                        state_d.inc     = inc_min_i;
                        state_d.restart = 1'b1;
                    end else begin
                        state_d.inc = up_cand;
                    end
                end
                MODE_DOWN: begin
                    if (dn_beyond) begin
                        state_d.inc     = inc_max_i;
                        state_d.restart = 1'b1;
                    end else begin
                        state_d.inc = dn_cand;
                    end
                end
                MODE_UPDOWN: begin
                    if (state_q.dir_up) begin
                        if (up_beyond) begin
                            state_d.dir_up = 1'b0;
                        end else begin
                            state_d.inc = up_cand;
                        end
                    end else if (dn_beyond) begin
                        state_d.inc     = inc_min_i;
                        state_d.dir_up  = 1'b1;
                        state_d.restart = 1'b1;
                    end else begin
                        state_d.inc = dn_cand;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.acc     <= '0;
            state_q.inc     <= '0;
            state_q.mode    <= MODE_FIXED;
            state_q.dir_up  <= 1'b1;
            state_q.restart <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign phase_o   = state_q.acc;
    assign restart_o = state_q.restart;
endmodule

// File: rtl/chirp_nco_chk.sv
module chirp_nco_chk #(
    parameter int PHASE_W = 32,
    parameter int DELTA_W = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               load_i,
    input logic [PHASE_W-1:0] offset_i,
    input logic [PHASE_W-1:0] inc_min_i,
    input logic [PHASE_W-1:0] inc_max_i,
    input logic [PHASE_W-1:0] phase_o,
    input logic               restart_o,
    input logic [PHASE_W-1:0] inc_q,
    input logic [1:0]         mode_q
);
    logic [PHASE_W-1:0] inc_hi;
    assign inc_hi = inc_q >> DELTA_W;

    // R1
    always_comb begin
        if (!rst_n) begin
            reset_state_chk: assert (phase_o == '0 && !restart_o);
        end
    end

    // R2
    load_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (phase_o == $past(offset_i)) && restart_o);

    // R3
    accum_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> phase_o == $past(phase_o) + $past(inc_q));

    // R4
    fixed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'd0 && !load_i) |=> $stable(inc_q));

    // R5
    low_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_o && mode_q != 2'd2) |-> inc_q == $past(inc_min_i));

    // R6
    high_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_o && mode_q == 2'd2) |-> inc_q == $past(inc_max_i));

    // R8
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_hi != $past(inc_hi)) |-> restart_o);
endmodule

bind chirp_nco chirp_nco_chk #(.PHASE_W(PHASE_W), .DELTA_W(DELTA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_i),
    .offset_i  (offset_i),
    .inc_min_i (inc_min_i),
    .inc_max_i (inc_max_i),
    .phase_o   (phase_o),
    .restart_o (restart_o),
    .inc_q     (state_q.inc),
    .mode_q    (state_q.mode)
);

// File: tb/chirp_nco_bench.sv
`timescale 1ns/1ps
module chirp_nco_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic [31:0] offset_i = '0;
    logic [31:0] inc_min_i = '0;
    logic [31:0] inc_max_i = '0;
    logic [23:0] delta_i = '0;
    logic [31:0] phase_o;
    logic        restart_o;

    int tests = 0;
    int fails = 0;

    // reference state
    logic [31:0] m_acc = '0;
    logic [31:0] m_inc = '0;
    logic [1:0]  m_mode = 2'd0;
    logic        m_up = 1'b1;
    logic        m_rst = 1'b0;

    always #2.5 clk = ~clk;

    chirp_nco u_chirp_nco (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_i),
        .mode_i    (mode_i),
        .offset_i  (offset_i),
        .inc_min_i (inc_min_i),
        .inc_max_i (inc_max_i),
        .delta_i   (delta_i),
        .phase_o   (phase_o),
        .restart_o (restart_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        logic [24:0] s;
        logic [31:0] c;
        logic        over;
        logic        under;
        logic [31:0] cd;
        s     = {1'b0, m_inc[23:0]} + {1'b0, delta_i};
        c     = {m_inc[31:24], s[23:0]};
        over  = s[24] || (c > inc_max_i);
        s     = {1'b0, m_inc[23:0]} - {1'b0, delta_i};
        cd    = {m_inc[31:24], s[23:0]};
        under = s[24] || (cd < inc_min_i);
        m_rst = 1'b0;
        if (load_i) begin
            m_acc  = offset_i;
            m_mode = mode_i;
            m_inc  = (mode_i == 2'd2) ? inc_max_i : inc_min_i;
            m_up   = 1'b1;
            m_rst  = 1'b1;
        end else begin
            m_acc = m_acc + m_inc;
            case (m_mode)
                2'd1: if (over) begin m_inc = inc_min_i; m_rst = 1'b1; end else m_inc = c;
                2'd2: if (under) begin m_inc = inc_max_i; m_rst = 1'b1; end else m_inc = cd;
                2'd3: begin
                    if (m_up) begin
                        if (over) m_up = 1'b0; else m_inc = c;
                    end else if (under) begin
                        m_inc = inc_min_i; m_up = 1'b1; m_rst = 1'b1;
                    end else begin
                        m_inc = cd;
                    end
                end
                default: ;
            endcase
        end
    endtask

    task automatic cycle(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check({tag, " phase"}, phase_o, m_acc);
        check({tag, " restart"}, {31'd0, restart_o}, {31'd0, m_rst});
    endtask

    task automatic start(input logic [1:0] m, input logic [31:0] off, input logic [31:0] lo,
                         input logic [31:0] hi, input logic [23:0] d);
        mode_i = m; offset_i = off; inc_min_i = lo; inc_max_i = hi; delta_i = d;
        load_i = 1'b1;
        cycle("R2");
        load_i = 1'b0;
        check("R2 offset", phase_o, off);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) cycle(tag);
    endtask

    initial begin
        #(200000 * 5);
        $display("FAIL watchdog: actual running expected finished");
        fails++;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int rcount;
        repeat (3) @(negedge clk);
        check("R1 phase", phase_o, 32'd0);
        check("R1 restart", {31'd0, restart_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 phase after release", phase_o, 32'd0);
        run(4, "R1");

        // fixed with wrap of the phase
        start(2'd0, 32'hFFFF_FF00, 32'h7FFF_FFFF, 32'h8000_0000, 24'd5);
        run(12, "R4");
        start(2'd0, 32'h0000_1000, 32'h0001_2345, 32'hFFFF_FFFF, 24'd9);
        run(12, "R3");

        // up chirp, exact and uneven top, then carry out of low field
        start(2'd1, 32'd7, 32'd100, 32'd130, 24'd10);
        rcount = 0;
        for (int i = 0; i < 40; i++) begin
            cycle("R5");
            if (restart_o) rcount++;
        end
        check("R5 restart count", rcount, 32'd10);
        start(2'd1, 32'd0, 32'd100, 32'd135, 24'd10);
        run(30, "R5");
        start(2'd1, 32'd3, 32'h01FF_FFF0, 32'hFFFF_FFFF, 24'd8);
        run(20, "R8");

        // down chirp, then borrow out of low field
        start(2'd2, 32'd11, 32'd50, 32'd200, 24'd30);
        run(30, "R6");
        start(2'd2, 32'd0, 32'd0, 32'h0500_002A, 24'h10);
        run(20, "R8");

        // up/down
        start(2'd3, 32'h1234_5678, 32'd0, 32'd1000, 24'd64);
        run(60, "R7");
        mode_i = 2'd0;
        run(40, "R9");
        mode_i = 2'd2;
        run(20, "R9");
        start(2'd3, 32'h0BAD_0000, 32'h0300_0100, 32'h0300_0400, 24'h40);
        run(25, "R7");
        // reload mid sweep
        start(2'd1, 32'h0000_0042, 32'd5, 32'd500, 24'd3);
        run(10, "R2");

        // near-exhaustive small sweep
        for (int m = 1; m < 4; m++)
            for (int d = 1; d < 10; d++)
                for (int hi = 20; hi < 27; hi++) begin
                    start(m[1:0], 32'(hi * 1000), 32'd3, 32'(hi), 24'(d));
                    run(40, (m == 1) ? "R5" : (m == 2) ? "R6" : "R7");
                end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule